// File: doc/BRIEF.md
# Pointer Address Generation Unit

This block turns an indirect data-space request into an effective byte address. The register file supplies the two bytes of the selected 16-bit pointer: the low byte from an even register and the high byte from the odd register above it. The caller also gives an access mode and a small unsigned displacement. One clock later the block returns the address to access, the region of the unified data map that the address falls in, and the offset inside that region. When the mode changes the pointer, it also returns the updated pointer value, the index of the register pair that receives it, and a write strobe. A second request kind reads a constant table. For that request the Z pointer becomes a program-memory word address plus a byte select, and no data access takes place.

The unified data map puts the working registers at the bottom. The I/O locations follow them, and then the SRAM. Every address above the end of the SRAM is reported as unmapped. A request that the addressing rules forbid raises an error strobe and causes no access and no write-back. The one-cycle latency leaves the second cycle of a two-cycle load or store free for the array access.

Top module: `ptr_agu`

## Requirements
- R1: After reset, and until the first request has been registered, `acc_valid`, `wb_en`, `tbl_valid` and `req_err` are all 0.
- R2: Pointer codes are X=0, Y=1 and Z=2. The pointer value is `{ptr_hi, ptr_lo}`. Plain mode (code 0) accesses the pointer value and does not write back. On write-back, `wb_reg` names the low register of the pair: X=26, Y=28, Z=30.
- R3: Post-increment mode (code 1) accesses the current pointer value and writes back the pointer plus 1.
- R4: Pre-decrement mode (code 2) writes back the pointer minus 1 and accesses that same decremented value.
- R5: Displacement mode (code 3) on Y or Z accesses the pointer plus the 6-bit unsigned `req_disp` (0 to 63) and does not write back.
- R6: All pointer arithmetic wraps modulo 2^16: 0xFFFF+1 gives 0x0000, 0x0000-1 gives 0xFFFF, and a displacement sum that carries out is truncated.
- R7: `acc_region` is 0 for addresses 0x00 to 0x1F (working registers, offset = address), 1 for 0x20 to 0x5F (I/O, offset = address-0x20), 2 for 0x60 to 0x15F (SRAM, offset = address-0x60) and 3 above that (unmapped, offset = address).
- R8: A table request (`req_table`=1) on Z ignores the mode, raises `tbl_valid`, and outputs `tbl_word` = Z[15:1] and `tbl_high` = Z[0]. It raises neither `acc_valid` nor `wb_en`.
- R9: Displacement mode on X, pointer code 3, or a table request on X or Y raises `req_err`. Such a request raises neither `acc_valid`, `wb_en` nor `tbl_valid`.
- R10: Each request produces exactly one of `acc_valid`, `tbl_valid` or `req_err` in the cycle after it is sampled. A cycle with no request produces none of them and no `wb_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_ptr | input | 2 | Pointer select: X=0, Y=1, Z=2 |
| req_mode | input | 2 | Plain=0, post-increment=1, pre-decrement=2, displacement=3 |
| req_table | input | 1 | Constant-table lookup through Z |
| req_disp | input | 6 | Unsigned displacement |
| ptr_lo | input | 8 | Low byte of the selected pointer |
| ptr_hi | input | 8 | High byte of the selected pointer |
| acc_valid | output | 1 | Data access address valid |
| acc_addr | output | 16 | Effective data address |
| acc_region | output | 2 | Region code of the address |
| acc_offset | output | 16 | Offset inside the region |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_reg | output | 5 | Low register index of the pair to update |
| wb_value | output | 16 | New pointer value |
| tbl_valid | output | 1 | Table lookup address valid |
| tbl_word | output | 15 | Program-memory word address |
| tbl_high | output | 1 | High-byte select within the word |
| req_err | output | 1 | Forbidden request |

## Verification
Post-increment and pre-decrement cause a data access and a pointer write-back in the same result cycle. These two results must disagree by one for post-increment and agree for pre-decrement. The bench provokes this with chains of back-to-back stepping requests on one pointer, where the pointer fed in comes from a register-file model that takes each expected write-back. A single wrong step therefore shows up in the address, the region and the write value of every later request. The pointer is also forced onto 0xFFFF and 0x0000 so that both functions wrap together, and it is walked across the 0x1F/0x20, 0x5F/0x60 and 0x15F/0x160 region edges.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;
   typedef enum logic [1:0] {PSEL_X = 2'd0, PSEL_Y = 2'd1, PSEL_Z = 2'd2, PSEL_NONE = 2'd3} psel_e;
   typedef enum logic [1:0] {AM_PLAIN = 2'd0, AM_POSTINC = 2'd1, AM_PREDEC = 2'd2, AM_DISP = 2'd3} amode_e;
   typedef enum logic [1:0] {RGN_GPR = 2'd0, RGN_IO = 2'd1, RGN_SRAM = 2'd2, RGN_NONE = 2'd3} rgn_e;
endpackage

// File: rtl/ptr_agu_calc.sv
module ptr_agu_calc
   import ptr_agu_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DISP_W    = 6,
   parameter bit DISP_ON_X = 1'b0
) (
   input  logic [1:0]        psel,
   input  logic [1:0]        amode,
   input  logic              tbl,
   input  logic [DISP_W-1:0] disp,
   input  logic [ADDR_W-1:0] ptr,
   output logic [ADDR_W-1:0] eff,
   output logic [ADDR_W-1:0] nxt,
   output logic              step,
   output logic              bad
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   psel_e  sel;
   amode_e md;
   logic   disp_ok;
   logic   [ADDR_W-1:0] inc_v, dec_v, sum_v;

   assign sel = psel_e'(psel);
   assign md  = amode_e'(amode);

   // variant: displacement legal on all pointers, or only on Y and Z
   generate
      if (DISP_ON_X) begin : g_disp_all
         assign disp_ok = 1'b1;
      end else begin : g_disp_yz
         assign disp_ok = (sel != PSEL_X);
      end
   endgenerate

   assign inc_v = ptr + ONE;
   assign dec_v = ptr - ONE;
   assign sum_v = ptr + {{(ADDR_W-DISP_W){1'b0}}, disp};

   always_comb begin
      bad = 1'b0;
      if (sel == PSEL_NONE)        bad = 1'b1;
      else if (tbl)                bad = (sel != PSEL_Z);
      else if (md == AM_DISP)      bad = !disp_ok;
   end

   always_comb begin
      eff  = ptr;
      nxt  = ptr;
      step = 1'b0;
      unique case (md)
         AM_PLAIN:   eff = ptr;
         AM_POSTINC: begin eff = ptr;   nxt = inc_v; step = 1'b1; end
         AM_PREDEC:  begin eff = dec_v; nxt = dec_v; step = 1'b1; end
         AM_DISP:    eff = sum_v;
         default:    eff = ptr;
      endcase
   end
endmodule

// File: rtl/ptr_agu_region.sv
module ptr_agu_region
   import ptr_agu_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int NUM_GPR    = 32,
   parameter int NUM_IO     = 64,
   parameter int SRAM_BYTES = 256
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [1:0]        rgn,
   output logic [ADDR_W-1:0] off
);
   localparam int            IO_BASE_I   = NUM_GPR;
   localparam int            SRAM_BASE_I = NUM_GPR + NUM_IO;
   localparam int            SRAM_END_I  = SRAM_BASE_I + SRAM_BYTES;
   localparam logic [ADDR_W:0]   LIM_IO   = (ADDR_W+1)'(IO_BASE_I);
   localparam logic [ADDR_W:0]   LIM_SRAM = (ADDR_W+1)'(SRAM_BASE_I);
   localparam logic [ADDR_W:0]   LIM_END  = (ADDR_W+1)'(SRAM_END_I);
   localparam logic [ADDR_W-1:0] B_IO     = ADDR_W'(IO_BASE_I);
   localparam logic [ADDR_W-1:0] B_SRAM   = ADDR_W'(SRAM_BASE_I);

   logic [ADDR_W:0] a_x;
   logic            in_sram;
   rgn_e            r;

   assign a_x = {1'b0, addr};

   generate
      if (SRAM_BYTES > 0) begin : g_sram
         assign in_sram = (a_x >= LIM_SRAM) && (a_x < LIM_END);
      end else begin : g_no_sram
         assign in_sram = 1'b0;
      end
   endgenerate

   always_comb begin
      if (a_x < LIM_IO) begin
         r   = RGN_GPR;
         off = addr;
      end else if (a_x < LIM_SRAM) begin
         r   = RGN_IO;
         off = addr - B_IO;
      end else if (in_sram) begin
         r   = RGN_SRAM;
         off = addr - B_SRAM;
      end else begin
         r   = RGN_NONE;
         off = addr;
      end
   end

   assign rgn = r;
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
   import ptr_agu_pkg::*;
#(
   parameter int REG_W      = 8,
   parameter int DISP_W     = 6,
   parameter int NUM_GPR    = 32,
   parameter int NUM_IO     = 64,
   parameter int SRAM_BYTES = 256,
   parameter int PTR_BASE   = 26,
   parameter bit DISP_ON_X  = 1'b0,
   localparam int ADDR_W    = 2 * REG_W,
   localparam int RIDX_W    = $clog2(NUM_GPR)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_ptr,
   input  logic [1:0]        req_mode,
   input  logic              req_table,
   input  logic [DISP_W-1:0] req_disp,
   input  logic [REG_W-1:0]  ptr_lo,
   input  logic [REG_W-1:0]  ptr_hi,
   output logic              acc_valid,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [1:0]        acc_region,
   output logic [ADDR_W-1:0] acc_offset,
   output logic              wb_en,
   output logic [RIDX_W-1:0] wb_reg,
   output logic [ADDR_W-1:0] wb_value,
   output logic              tbl_valid,
   output logic [ADDR_W-2:0] tbl_word,
   output logic              tbl_high,
   output logic              req_err
);
   // elaboration checks on the parameter set
   generate
      if (DISP_W >= ADDR_W) begin : g_chk_disp
         $error("displacement must be narrower than the address");
      end
      if ((PTR_BASE % 2) != 0 || PTR_BASE + 6 > NUM_GPR) begin : g_chk_base
         $error("pointer pairs must be even-aligned inside the register file");
      end
      if (NUM_GPR + NUM_IO + SRAM_BYTES > (1 << ADDR_W)) begin : g_chk_map
         $error("data map exceeds the address space");
      end
      if (NUM_GPR < 8 || NUM_IO < 1) begin : g_chk_sizes
         $error("register file or I/O space too small");
      end
   endgenerate

   logic [ADDR_W-1:0] ptr_v, eff_v, nxt_v, off_v;
   logic              step_v, bad_v;
   logic [1:0]        rgn_v;
   logic [RIDX_W-1:0] pair_idx;

   assign ptr_v    = {ptr_hi, ptr_lo};
   assign pair_idx = RIDX_W'(PTR_BASE) + RIDX_W'({req_ptr, 1'b0});

   ptr_agu_calc #(
      .ADDR_W   (ADDR_W),
      .DISP_W   (DISP_W),
      .DISP_ON_X(DISP_ON_X)
   ) u_calc (
      .psel (req_ptr),
      .amode(req_mode),
      .tbl  (req_table),
      .disp (req_disp),
      .ptr  (ptr_v),
      .eff  (eff_v),
      .nxt  (nxt_v),
      .step (step_v),
      .bad  (bad_v)
   );

   ptr_agu_region #(
      .ADDR_W    (ADDR_W),
      .NUM_GPR   (NUM_GPR),
      .NUM_IO    (NUM_IO),
      .SRAM_BYTES(SRAM_BYTES)
   ) u_region (
      .addr(eff_v),
      .rgn (rgn_v),
      .off (off_v)
   );

   // result stage: one register between request and outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_valid  <= 1'b0;
         wb_en      <= 1'b0;
         tbl_valid  <= 1'b0;
         req_err    <= 1'b0;
         acc_addr   <= '0;
         acc_region <= '0;
         acc_offset <= '0;
         wb_reg     <= '0;
         wb_value   <= '0;
         tbl_word   <= '0;
         tbl_high   <= 1'b0;
      end else begin
         acc_valid <= req_valid && !bad_v && !req_table;
         wb_en     <= req_valid && !bad_v && !req_table && step_v;
         tbl_valid <= req_valid && !bad_v && req_table;
         req_err   <= req_valid && bad_v;
         if (req_valid) begin
            acc_addr   <= eff_v;
            acc_region <= rgn_v;
            acc_offset <= off_v;
            wb_reg     <= pair_idx;
            wb_value   <= nxt_v;
            tbl_word   <= ptr_v[ADDR_W-1:1];
            tbl_high   <= ptr_v[0];
         end
      end
   end
endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk #(
   parameter int ADDR_W   = 16,
   parameter int RIDX_W   = 5,
   parameter int NUM_GPR  = 32,
   parameter int PTR_BASE = 26
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              acc_valid,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [1:0]        acc_region,
   input logic              wb_en,
   input logic [RIDX_W-1:0] wb_reg,
   input logic [ADDR_W-1:0] wb_value,
   input logic              tbl_valid,
   input logic              req_err
);
   localparam logic [RIDX_W-1:0] P0 = RIDX_W'(PTR_BASE);
   localparam logic [RIDX_W-1:0] P1 = RIDX_W'(PTR_BASE + 2);
   localparam logic [RIDX_W-1:0] P2 = RIDX_W'(PTR_BASE + 4);

   AST_WB_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_reg == P0 || wb_reg == P1 || wb_reg == P2)); // R2

   AST_WB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_value == acc_addr + ADDR_W'(1)) || (wb_value == acc_addr)); // R3

   AST_WB_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> acc_valid); // R4

   AST_GPR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_region == 2'd0) |-> (acc_addr < ADDR_W'(NUM_GPR))); // R7

   AST_TABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_valid |-> (!wb_en && !acc_valid)); // R8

   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> (!acc_valid && !wb_en && !tbl_valid)); // R9

   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ($countones({acc_valid, tbl_valid, req_err}) == 1)); // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!acc_valid && !tbl_valid && !req_err && !wb_en)); // R10
endmodule

bind ptr_agu ptr_agu_chk #(
   .ADDR_W  (ADDR_W),
   .RIDX_W  (RIDX_W),
   .NUM_GPR (NUM_GPR),
   .PTR_BASE(PTR_BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .acc_valid (acc_valid),
   .acc_addr  (acc_addr),
   .acc_region(acc_region),
   .wb_en     (wb_en),
   .wb_reg    (wb_reg),
   .wb_value  (wb_value),
   .tbl_valid (tbl_valid),
   .req_err   (req_err)
);

// File: tb/test_ptr_agu.sv
`timescale 1ns/1ps
module test_ptr_agu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_ptr = '0;
   logic [1:0]  req_mode = '0;
   logic        req_table = 1'b0;
   logic [5:0]  req_disp = '0;
   logic [7:0]  ptr_lo = '0;
   logic [7:0]  ptr_hi = '0;
   logic        acc_valid, wb_en, tbl_valid, tbl_high, req_err;
   logic [15:0] acc_addr, acc_offset, wb_value;
   logic [1:0]  acc_region;
   logic [4:0]  wb_reg;
   logic [14:0] tbl_word;

   always #2.5 clk = ~clk;

   ptr_agu i_ptr_agu (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ptr(req_ptr),
      .req_mode(req_mode), .req_table(req_table), .req_disp(req_disp),
      .ptr_lo(ptr_lo), .ptr_hi(ptr_hi), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_region(acc_region), .acc_offset(acc_offset), .wb_en(wb_en), .wb_reg(wb_reg),
      .wb_value(wb_value), .tbl_valid(tbl_valid), .tbl_word(tbl_word),
      .tbl_high(tbl_high), .req_err(req_err)
   );

   typedef struct {
      bit av; bit [15:0] addr; bit [1:0] rgn; bit [15:0] off;
      bit wb; bit [4:0] wr; bit [15:0] wv;
      bit tv; bit [14:0] tw; bit th; bit er; string tag;
   } exp_t;

   exp_t        sb[$];
   bit   [15:0] ptrs [0:2];
   int          checks = 0;
   int          fails  = 0;

   task automatic cmp(input string tag, input string fld, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, fld, act, exp);
      end
   endtask

   // driver: applies one request (or an idle cycle) and queues its expected result
   task automatic issue(input bit v, input int sel, input int md, input bit tb,
                        input int q, input string tag);
      exp_t e;
      bit [15:0] p, a, nv;
      bit bad, step;
      @(negedge clk);
      p = (sel < 3) ? ptrs[sel] : 16'h0;
      req_valid = v; req_ptr = sel[1:0]; req_mode = md[1:0]; req_table = tb;
      req_disp = q[5:0]; ptr_lo = p[7:0]; ptr_hi = p[15:8];
      e.av = 0; e.addr = 0; e.rgn = 0; e.off = 0; e.wb = 0; e.wr = 0; e.wv = 0;
      e.tv = 0; e.tw = 0; e.th = 0; e.er = 0; e.tag = tag;
      if (v) begin
         bad = (sel == 3) || (tb && sel != 2) || (!tb && md == 3 && sel == 0);
         if (bad) e.er = 1;
         else if (tb) begin e.tv = 1; e.tw = p[15:1]; e.th = p[0]; end
         else begin
            step = 0; nv = p; a = p;
            case (md)
               1: begin nv = p + 16'd1; step = 1; end
               2: begin nv = p - 16'd1; a = nv; step = 1; end
               3: a = p + 16'(q);
               default: a = p;
            endcase
            e.av = 1; e.addr = a;
            if (a < 16'h20)       begin e.rgn = 0; e.off = a; end
            else if (a < 16'h60)  begin e.rgn = 1; e.off = a - 16'h20; end
            else if (a < 16'h160) begin e.rgn = 2; e.off = a - 16'h60; end
            else                  begin e.rgn = 3; e.off = a; end
            if (step) begin
               e.wb = 1; e.wr = 5'(26 + 2 * sel); e.wv = nv; ptrs[sel] = nv;
            end
         end
      end
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) issue(0, 0, 0, 0, 0, "R10 idle");
   endtask

   // monitor: compares each registered result one step after its clock edge
   always @(posedge clk) begin
      exp_t e;
      #1;
      if (sb.size() > 0) begin
         e = sb.pop_front();
         cmp(e.tag, "acc_valid", int'(acc_valid), int'(e.av));
         cmp(e.tag, "wb_en",     int'(wb_en),     int'(e.wb));
         cmp(e.tag, "tbl_valid", int'(tbl_valid), int'(e.tv));
         cmp(e.tag, "req_err",   int'(req_err),   int'(e.er));
         if (e.av) begin
            cmp(e.tag, "acc_addr",   int'(acc_addr),   int'(e.addr));
            cmp(e.tag, "acc_region", int'(acc_region), int'(e.rgn));
            cmp(e.tag, "acc_offset", int'(acc_offset), int'(e.off));
         end
         if (e.wb) begin
            cmp(e.tag, "wb_reg",   int'(wb_reg),   int'(e.wr));
            cmp(e.tag, "wb_value", int'(wb_value), int'(e.wv));
         end
         if (e.tv) begin
            cmp(e.tag, "tbl_word", int'(tbl_word), int'(e.tw));
            cmp(e.tag, "tbl_high", int'(tbl_high), int'(e.th));
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      ptrs[0] = 16'h0010; ptrs[1] = 16'h005E; ptrs[2] = 16'h0100;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: strobes quiet out of reset
      cmp("R1", "acc_valid", int'(acc_valid), 0);
      cmp("R1", "wb_en",     int'(wb_en),     0);
      cmp("R1", "tbl_valid", int'(tbl_valid), 0);
      cmp("R1", "req_err",   int'(req_err),   0);
      rst_n = 1'b1;
      idle(2);
      issue(1, 0, 0, 0, 0, "R2 plain X");
      issue(1, 1, 0, 0, 0, "R7 plain Y io");
      // back-to-back post-increment chain across the I/O/SRAM edge
      issue(1, 1, 1, 0, 0, "R3 postinc Y");
      issue(1, 1, 1, 0, 0, "R3 postinc Y edge");
      issue(1, 1, 0, 0, 0, "R7 sram base");
      issue(1, 0, 2, 0, 0, "R4 predec X");
      issue(1, 0, 2, 0, 0, "R4 predec X again");
      issue(1, 1, 3, 0, 63, "R5 disp Y max");
      issue(1, 2, 3, 0, 0, "R5 disp Z zero");
      idle(1);
      issue(1, 0, 3, 0, 5, "R9 disp on X");
      issue(1, 3, 0, 0, 0, "R9 bad pointer");
      issue(1, 1, 0, 1, 0, "R9 table on Y");
      issue(1, 0, 1, 1, 0, "R9 table on X");
      issue(1, 0, 0, 0, 0, "R9 X untouched");
      issue(1, 2, 0, 1, 0, "R8 table Z even");
      issue(1, 2, 1, 0, 0, "R3 postinc Z");
      issue(1, 2, 2, 1, 0, "R8 table Z odd mode ignored");
      ptrs[0] = 16'h001F; issue(1, 0, 1, 0, 0, "R7 gpr top");
      issue(1, 0, 0, 0, 0, "R7 io base");
      ptrs[2] = 16'h015F; issue(1, 2, 1, 0, 0, "R7 sram top");
      issue(1, 2, 0, 0, 0, "R7 unmapped");
      ptrs[2] = 16'hFFFF; issue(1, 2, 1, 0, 0, "R6 postinc wrap");
      issue(1, 2, 0, 0, 0, "R6 after wrap");
      ptrs[0] = 16'h0000; issue(1, 0, 2, 0, 0, "R6 predec wrap");
      ptrs[1] = 16'hFFF0; issue(1, 1, 3, 0, 63, "R6 disp wrap");
      issue(1, 1, 2, 0, 0, "R4 predec Y high");
      idle(3);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule